// File: doc/BRIEF.md
# JTAG Instruction Register

This block is the instruction register of a boundary-scan test port. The TAP controller routes it between TDI and TDO only for instruction scans and drives it with one-cycle strobes. On a capture strobe the shift stage loads a fixed pattern. On each shift strobe that pattern leaves on TDO, least significant bit first, while the new opcode enters from TDI at the most significant end. On an update strobe the shifted word moves into the instruction latch. That latch drives the rest of the test logic. The TAP controller and the data registers are outside this block.

The register length is a parameter, normally 10 or 14 bits. Every opcode shares a common 6-bit core in the low bits, and all bits above the core must be ones. The decoder gives one select line per supported instruction. It matches the core only when that padding is intact. Any other word selects bypass, the safe default.

Top module: `jtag_ir`

## Requirements
- R1: When `trst_n` is low (asynchronous) or `tlr_i` is high at a rising TCK edge, `ir_o` becomes all ones and `sel_o` selects bypass.
- R2: A rising edge with `capture_ir_i` high loads the shift stage with a pattern whose bit 0 is 1 and whose other bits are 0. Bit 0 then appears on `tdo_o`.
- R3: Each rising edge with `shift_ir_i` high, and no capture or reset strobe, moves the stage one place toward bit 0 and puts `tdi_i` into the top bit. `tdo_o` always shows bit 0, so after IR_LEN shifts the stage holds the word shifted in, and a further IR_LEN shifts bring that word out on `tdo_o`.
- R4: `ir_o` changes only on an update strobe or on reset. Capturing and shifting leave it unchanged.
- R5: A rising edge with `update_ir_i` high copies the shift stage into `ir_o`.
- R6: The select lines are `sel_o` bit 0 EXTEST (core 000000), bit 1 SAMPLE (000001), bit 2 USER1 (000010), bit 3 IDCODE (001001) and bit 4 BYPASS (111111). A line is set when `ir_o[5:0]` equals its core and every bit of `ir_o` above bit 5 is 1.
- R7: If any bit of `ir_o` above bit 5 is 0, only the bypass line is set, whatever the core holds.
- R8: A core value not listed in R6, with intact padding, sets only the bypass line.
- R9: Exactly one bit of `sel_o` is set on every cycle out of reset.
- R10: On a rising edge with no capture, shift or reset strobe, the shift stage and `tdo_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr_i | input | 1 | Test-logic-reset state strobe |
| capture_ir_i | input | 1 | Capture strobe for the instruction scan |
| shift_ir_i | input | 1 | Shift strobe for the instruction scan |
| update_ir_i | input | 1 | Update strobe for the instruction scan |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, bit 0 of the shift stage |
| ir_o | output | IR_LEN | Current instruction |
| sel_o | output | 5 | One-hot instruction select (bit order in R6) |

## Verification
The assertions check the per-edge rules on every cycle: reset forcing all ones, the capture value, the one-place shift, the latch holding between updates, the update copy, the padding fallback, one-hot selects and a quiet shift stage. Only the bench scenarios can show whole scans working end to end. These include the capture pattern coming out across a full scan, a word surviving idle gaps, a second scan without capture returning the first word, and each opcode, a broken-padding word and an unlisted core decoding to the expected select.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;

    localparam int OPC_W   = 6;
    localparam int NUM_SEL = 5;

    localparam int SEL_EXTEST = 0;
    localparam int SEL_SAMPLE = 1;
    localparam int SEL_USER1  = 2;
    localparam int SEL_IDCODE = 3;
    localparam int SEL_BYPASS = 4;

    // Core opcode recognised for each select index; bypass is the fallback.
    function automatic logic [OPC_W-1:0] core_of(input int idx);
        case (idx)
            SEL_EXTEST: core_of = 6'b000000;
            SEL_SAMPLE: core_of = 6'b000001;
            SEL_USER1:  core_of = 6'b000010;
            SEL_IDCODE: core_of = 6'b001001;
            default:    core_of = 6'b111111;
        endcase
    endfunction

endpackage

// File: rtl/jtag_ir_regs.sv
module jtag_ir_regs #(
    parameter int IR_LEN = 10
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tlr_i,
    input  logic              capture_ir_i,
    input  logic              shift_ir_i,
    input  logic              update_ir_i,
    input  logic              tdi_i,
    output logic [IR_LEN-1:0] shift_o,
    output logic [IR_LEN-1:0] inst_o
);

    localparam logic [IR_LEN-1:0] CAPTURE_VAL = {{(IR_LEN-2){1'b0}}, 2'b01};
    localparam logic [IR_LEN-1:0] BYPASS_VAL  = '1;

    typedef struct packed {
        logic [IR_LEN-1:0] shift;
        logic [IR_LEN-1:0] inst;
    } regs_t;

    localparam regs_t RESET_VAL = '{shift: CAPTURE_VAL, inst: BYPASS_VAL};

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (tlr_i) begin
            state_d.shift = CAPTURE_VAL;
            state_d.inst  = BYPASS_VAL;
        end else begin
            if (capture_ir_i) begin
                state_d.shift = CAPTURE_VAL;
            end else if (shift_ir_i) begin
                state_d.shift = {tdi_i, state_q.shift[IR_LEN-1:1]};
            end
            if (update_ir_i) begin
                state_d.inst = state_q.shift;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= RESET_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign shift_o = state_q.shift;
    assign inst_o  = state_q.inst;

endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
    import jtag_ir_pkg::*;
#(
    parameter int IR_LEN = 10
) (
    input  logic [IR_LEN-1:0]  inst_i,
    output logic [NUM_SEL-1:0] sel_o
);

    logic                 pad_ok;
    logic [OPC_W-1:0]     core;
    logic [NUM_SEL-2:0]   hit;

    assign core = inst_i[OPC_W-1:0];

    generate
        if (IR_LEN > OPC_W) begin : g_pad
            assign pad_ok = &inst_i[IR_LEN-1:OPC_W];
        end else begin : g_nopad
            assign pad_ok = 1'b1;
        end
    endgenerate

    generate
        for (genvar i = 0; i < NUM_SEL-1; i++) begin : g_match
            assign hit[i] = pad_ok && (core == core_of(i));
        end
    endgenerate

    assign sel_o = {~|hit, hit};

endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
    import jtag_ir_pkg::*;
#(
    parameter int IR_LEN = 10
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tlr_i,
    input  logic               capture_ir_i,
    input  logic               shift_ir_i,
    input  logic               update_ir_i,
    input  logic               tdi_i,
    output logic               tdo_o,
    output logic [IR_LEN-1:0]  ir_o,
    output logic [NUM_SEL-1:0] sel_o
);

    logic [IR_LEN-1:0] shift_w;
    logic [IR_LEN-1:0] inst_w;

    jtag_ir_regs #(.IR_LEN(IR_LEN)) u_regs (
        .tck          (tck),
        .trst_n       (trst_n),
        .tlr_i        (tlr_i),
        .capture_ir_i (capture_ir_i),
        .shift_ir_i   (shift_ir_i),
        .update_ir_i  (update_ir_i),
        .tdi_i        (tdi_i),
        .shift_o      (shift_w),
        .inst_o       (inst_w)
    );

    jtag_ir_decode #(.IR_LEN(IR_LEN)) u_decode (
        .inst_i (inst_w),
        .sel_o  (sel_o)
    );

    assign tdo_o = shift_w[0];
    assign ir_o  = inst_w;

endmodule

// File: rtl/jtag_ir_checker.sv
module jtag_ir_checker
    import jtag_ir_pkg::*;
#(
    parameter int IR_LEN = 10
) (
    input logic               tck,
    input logic               trst_n,
    input logic               tlr_i,
    input logic               capture_ir_i,
    input logic               shift_ir_i,
    input logic               update_ir_i,
    input logic               tdi_i,
    input logic               tdo_o,
    input logic [IR_LEN-1:0]  ir_o,
    input logic [NUM_SEL-1:0] sel_o,
    input logic [IR_LEN-1:0]  shreg_i
);

    p_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
        tlr_i |=> (ir_o == '1) && sel_o[SEL_BYPASS]);

    p_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (capture_ir_i && !tlr_i) |=> (tdo_o == 1'b1) && (shreg_i[IR_LEN-1:1] == '0));

    p_shift_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_ir_i && !capture_ir_i && !tlr_i)
        |=> (tdo_o == $past(shreg_i[1])) && (shreg_i[IR_LEN-1] == $past(tdi_i)));

    p_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (!update_ir_i && !tlr_i) |=> $stable(ir_o));

    p_update_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (update_ir_i && !tlr_i) |=> (ir_o == $past(shreg_i)));

    generate
        if (IR_LEN > OPC_W) begin : g_pad_chk
            p_pad_r7: assert property (@(posedge tck) disable iff (!trst_n)
                !(&ir_o[IR_LEN-1:OPC_W]) |-> sel_o[SEL_BYPASS]);
        end
    endgenerate

    p_onehot_r9: assert property (@(posedge tck) disable iff (!trst_n)
        $countones(sel_o) == 1);

    p_idle_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (!capture_ir_i && !shift_ir_i && !tlr_i) |=> $stable(shreg_i) && $stable(tdo_o));

endmodule

bind jtag_ir jtag_ir_checker #(.IR_LEN(IR_LEN)) u_chk (
    .tck          (tck),
    .trst_n       (trst_n),
    .tlr_i        (tlr_i),
    .capture_ir_i (capture_ir_i),
    .shift_ir_i   (shift_ir_i),
    .update_ir_i  (update_ir_i),
    .tdi_i        (tdi_i),
    .tdo_o        (tdo_o),
    .ir_o         (ir_o),
    .sel_o        (sel_o),
    .shreg_i      (shift_w)
);

// File: tb/jtag_ir_tb_top.sv
module jtag_ir_tb_top;

    localparam int L  = 10;
    localparam int NS = 5;
    localparam logic [L-1:0] CAP  = {{(L-2){1'b0}}, 2'b01};
    localparam logic [L-1:0] PADS = {(L-6){1'b1}} << 6;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tlr = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic          tdo;
    logic [L-1:0]  ir;
    logic [NS-1:0] sel;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    logic exp_q[$];

    always #2 tck = ~tck;

    jtag_ir #(.IR_LEN(L)) dut_i (
        .tck(tck), .trst_n(trst_n), .tlr_i(tlr), .capture_ir_i(cap),
        .shift_ir_i(sh), .update_ir_i(upd), .tdi_i(tdi),
        .tdo_o(tdo), .ir_o(ir), .sel_o(sel)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected select from the opcode table and padding rule.
    function automatic logic [NS-1:0] exp_sel(input logic [L-1:0] w);
        if ((w & PADS) != PADS) return 5'b10000;
        case (w[5:0])
            6'b000000: return 5'b00001;
            6'b000001: return 5'b00010;
            6'b000010: return 5'b00100;
            6'b001001: return 5'b01000;
            default:   return 5'b10000;
        endcase
    endfunction

    // Monitor: pops the expected TDO bit on every shift cycle.
    always @(negedge tck) begin
        if (trst_n && sh && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected shift", {31'd0, tdo}, 32'd0);
            end else begin
                logic e;
                e = exp_q.pop_front();
                chk(tdo === e, "R2/R3 tdo bit", {31'd0, tdo}, {31'd0, e});
            end
        end
    end

    task automatic cyc(input logic c, input logic s, input logic u, input logic t, input logic d);
        @(posedge tck); #1;
        cap = c; sh = s; upd = u; tlr = t; tdi = d;
    endtask

    task automatic scan(input logic [L-1:0] w, input logic [L-1:0] out, input bit do_cap);
        if (do_cap) cyc(1, 0, 0, 0, 0);
        for (int k = 0; k < L; k++) begin
            exp_q.push_back(out[k]);
            cyc(0, 1, 0, 0, w[k]);
        end
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic update_and_check(input logic [L-1:0] w, input string req);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk(ir === w, {req, " ir value"}, 32'(ir), 32'(w));
        chk(sel === exp_sel(w), {req, " select"}, 32'(sel), 32'(exp_sel(w)));
        chk($countones(sel) == 1, "R9 one-hot", 32'(sel), 32'd1);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [L-1:0] w1, w2;
        repeat (3) @(posedge tck);
        #1;
        chk(ir === '1, "R1 reset ir", 32'(ir), 32'(L'('1)));
        chk(sel === 5'b10000, "R1 reset select", 32'(sel), 32'h10);
        chk(tdo === 1'b1, "R2 reset tdo", {31'd0, tdo}, 32'd1);
        trst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);

        // IDCODE scan; latch untouched until update (R4)
        scan(PADS | 10'b001001, CAP, 1);
        chk(ir === '1, "R4 hold during scan", 32'(ir), 32'(L'('1)));
        update_and_check(PADS | 10'b001001, "R5/R6 idcode");

        scan(PADS | 10'b000000, CAP, 1); update_and_check(PADS | 10'b000000, "R6 extest");
        scan(PADS | 10'b000001, CAP, 1); update_and_check(PADS | 10'b000001, "R6 sample");
        scan(PADS | 10'b000010, CAP, 1); update_and_check(PADS | 10'b000010, "R6 user1");

        // Chained scan with idle gaps: second pass returns the first word (R3, R10)
        w1 = 10'b1011001101;
        w2 = PADS | 10'b001001;
        scan(w1, CAP, 1);
        repeat (3) cyc(0, 0, 0, 0, 0);
        scan(w2, w1, 0);
        chk(ir === (PADS | 10'b000010), "R4 hold after shifting", 32'(ir), 32'(PADS | 10'b000010));
        update_and_check(w2, "R3 chained idcode");

        // Broken padding with an IDCODE core (R7)
        w1 = 10'b0111_001001;
        scan(w1, CAP, 1); update_and_check(w1, "R7 bad padding");

        // Unlisted core with intact padding (R8)
        w1 = PADS | 10'b000111;
        scan(w1, CAP, 1); update_and_check(w1, "R8 unlisted");

        // Test-logic-reset strobe (R1)
        scan(PADS | 10'b000001, CAP, 1); update_and_check(PADS | 10'b000001, "R6 sample again");
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        chk(ir === '1, "R1 tlr ir", 32'(ir), 32'(L'('1)));
        chk(sel === 5'b10000, "R1 tlr select", 32'(sel), 32'h10);

        // Asynchronous reset mid-run (R1)
        scan(PADS | 10'b000000, CAP, 1); update_and_check(PADS | 10'b000000, "R6 extest again");
        #1 trst_n = 1'b0;
        #0.5;
        chk(ir === '1, "R1 async reset ir", 32'(ir), 32'(L'('1)));
        chk(tdo === 1'b1, "R1 async reset tdo", {31'd0, tdo}, 32'd1);
        @(posedge tck); #1 trst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);

        chk(exp_q.size() == 0, "R3 all bits observed", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule